// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives characters from one idle-high asynchronous serial line. It runs from a single system clock and an oversampling tick supplied from outside, sixteen ticks per bit. A falling level on the line starts a character, and a half-bit check rejects short glitches. The receiver then samples 7 or 8 data bits at their centres, least significant bit first. It takes an optional parity bit and one or two stop bits.

When the character is complete, a check stage tests parity and the first stop bit. A status stage then decides whether the character enters the receive data register, and which flag it sets. A clean character sets the data-ready flag. A parity or stop-bit fault still loads the character but raises an error flag instead of data-ready. A character that finishes while data-ready is still high is dropped and raises the overrun flag. While any error flag is high, the receiver starts no new character. Each flag has its own clear strobe. One enable gates two interrupt requests: one for received data and one for receive errors.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, rx_data is 0 and every flag and interrupt output is 0.
- R2: In 8-bit mode (cfg_len7=0), a frame is a 0 start bit, 8 data bits sent LSB first, optional parity, and a 1 stop bit. A clean frame loads the data into rx_data and sets ready.
- R3: With cfg_len7=1, only 7 data bits are received, and rx_data[7] reads 0.
- R4: With cfg_par_en=1, the parity bit follows the data. The count of ones in data plus parity must be even when cfg_par_odd=0 and odd when cfg_par_odd=1. On a mismatch, parity_err is set, the data is still loaded, and ready stays 0.
- R5: A 0 in the first stop bit sets frame_err. The data is still loaded and ready stays 0.
- R6: With cfg_two_stop=1, a second stop bit is expected but not checked: a 0 there causes no error.
- R7: If a character completes while ready is 1, overrun is set, rx_data keeps its old value, and ready stays 1.
- R8: While overrun, frame_err or parity_err is 1, no new character is received; rx_data and ready do not change.
- R9: A low pulse on the line that is high again at the middle of the start bit (8 ticks in) is ignored. The next real frame is then received correctly.
- R10: irq_rxfull equals irq_en AND ready. irq_rxerr equals irq_en AND (overrun OR frame_err OR parity_err).
- R11: Each single-cycle clear strobe clears only its own flag. A flag being set by a completing character wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Serial data line, idle high, asynchronous |
| os_tick | input | 1 | One-cycle pulse, 16 per bit time |
| cfg_len7 | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| cfg_par_en | input | 1 | 1 = parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| irq_en | input | 1 | Enable for both interrupt requests |
| clr_ready | input | 1 | Clear strobe for ready |
| clr_overrun | input | 1 | Clear strobe for overrun |
| clr_frame | input | 1 | Clear strobe for frame_err |
| clr_parity | input | 1 | Clear strobe for parity_err |
| rx_data | output | 8 | Receive data register |
| ready | output | 1 | Data-ready flag |
| overrun | output | 1 | Overrun flag |
| frame_err | output | 1 | Framing error flag |
| parity_err | output | 1 | Parity error flag |
| irq_rxfull | output | 1 | Receive-data-full interrupt request |
| irq_rxerr | output | 1 | Receive-error interrupt request |

## Verification
Frames are sent with patterns chosen to tell apart different faults:
- Asymmetric bytes such as 0xA5 and 0x5A show whether the bit order is reversed or shifted by one.
- A 7-bit frame sent after a byte whose top bit was set shows whether rx_data[7] is masked.
- Good and bad parity under both even and odd settings, and a zero stop bit, separate "loaded with error" from "loaded clean".
- A zero second stop bit confirms that it is not checked.
- A short low glitch placed before a real frame shows whether start detection misaligns.
- Frames sent while a flag is still pending separate overrun from the blocked state, and show that the old data is kept.

// File: rtl/serial_rx_pkg.sv
// Package: shared types for the asynchronous serial receiver.
// Assumes at most 8 data bits per character.
package serial_rx_pkg;

    parameter int unsigned RX_MAX_BITS = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP1,
        RX_STOP2
    } rx_state_t;

    typedef struct packed {
        logic [RX_MAX_BITS-1:0] data;
        logic                   par_bit;
        logic                   stop_bit;
    } rx_frame_t;

endpackage

// File: rtl/serial_rx_sync.sv
// Module: serial_rx_sync
// Brings the asynchronous serial line into the clock domain through a
// chain of flops. Assumes an idle-high line, so the chain resets to 1.
module serial_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: capture the raw line into the first stage
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                // Purpose: pass the value down the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b1;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/serial_rx_framer.sv
// Module: serial_rx_framer
// Finds the start bit, confirms it at mid-bit, and samples the data,
// parity and stop bits at their centres using OVS ticks per bit.
// Raises done for one cycle with the captured frame after the first stop
// bit. Assumes the configuration inputs are static while a frame is in
// progress. Starts no frame while hold_off is high.
module serial_rx_framer
    import serial_rx_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      line_s,
    input  logic      hold_off,
    input  logic      cfg_len7,
    input  logic      cfg_par_en,
    input  logic      cfg_two_stop,
    output logic      done,
    output rx_frame_t frame
);
    localparam int unsigned CNT_W = $clog2(OVS);
    localparam int unsigned IDX_W = $clog2(RX_MAX_BITS);
    localparam logic [CNT_W-1:0] HALF_END = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] FULL_END = CNT_W'(OVS - 1);

    rx_state_t              state_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [IDX_W-1:0]       idx_q;
    logic [RX_MAX_BITS-1:0] shift_q;
    logic                   par_q;
    logic [IDX_W-1:0]       last_idx;
    logic                   at_centre;

    // Purpose: index of the final data bit for the configured length
    always_comb begin
        last_idx = cfg_len7 ? IDX_W'(RX_MAX_BITS - 2) : IDX_W'(RX_MAX_BITS - 1);
    end

    // Purpose: flag the tick that falls at the centre of the current bit
    always_comb begin
        at_centre = tick && (cnt_q == FULL_END);
    end

    // Purpose: receive state machine, bit timing and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            par_q   <= 1'b0;
            done    <= 1'b0;
            frame   <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if (tick && !hold_off && !line_s) begin
                        state_q <= RX_START;
                        cnt_q   <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (cnt_q == HALF_END) begin
                            cnt_q   <= '0;
                            idx_q   <= '0;
                            shift_q <= '0;
                            state_q <= line_s ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (at_centre) begin
                        cnt_q          <= '0;
                        shift_q[idx_q] <= line_s;
                        if (idx_q == last_idx) begin
                            state_q <= cfg_par_en ? RX_PARITY : RX_STOP1;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (at_centre) begin
                        cnt_q   <= '0;
                        par_q   <= line_s;
                        state_q <= RX_STOP1;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP1: begin
                    if (at_centre) begin
                        cnt_q          <= '0;
                        done           <= 1'b1;
                        frame.data     <= shift_q;
                        frame.par_bit  <= par_q;
                        frame.stop_bit <= line_s;
                        state_q        <= cfg_two_stop ? RX_STOP2 : RX_IDLE;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP2: begin
                    if (at_centre) begin
                        cnt_q   <= '0;
                        state_q <= RX_IDLE;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    // R8
    blocked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_IDLE && hold_off) |=> (state_q == RX_IDLE));

    // R9
    start_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_START) |=> (state_q inside {RX_START, RX_DATA, RX_IDLE}));
endmodule

// File: rtl/serial_rx_check.sv
// Module: serial_rx_check
// Combinational checks on a captured frame: masks the data to the
// configured length, tests parity against the odd/even setting, and tests
// the first stop bit. Assumes the frame holds still while done is high.
module serial_rx_check
    import serial_rx_pkg::*;
(
    input  rx_frame_t              frame,
    input  logic                   cfg_len7,
    input  logic                   cfg_par_en,
    input  logic                   cfg_par_odd,
    output logic [RX_MAX_BITS-1:0] data_out,
    output logic                   par_bad,
    output logic                   stop_bad
);
    logic [RX_MAX_BITS-1:0] len_mask;

    // Purpose: keep only the bits that belong to the configured length
    always_comb begin
        len_mask = cfg_len7 ? {1'b0, {(RX_MAX_BITS-1){1'b1}}} : {RX_MAX_BITS{1'b1}};
        data_out = frame.data & len_mask;
    end

    // Purpose: parity and stop-bit verdicts
    always_comb begin
        par_bad  = cfg_par_en && (((^data_out) ^ frame.par_bit) != cfg_par_odd);
        stop_bad = !frame.stop_bit;
    end
endmodule

// File: rtl/serial_rx_status.sv
// Module: serial_rx_status
// Holds the receive data register and the four flags. It decides on each
// completed character whether to load it, and drives both interrupt
// requests. Assumes done is a one-cycle pulse. A set on completion wins
// over a clear strobe in the same cycle.
module serial_rx_status
    import serial_rx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   done,
    input  logic [RX_MAX_BITS-1:0] data_in,
    input  logic                   par_bad,
    input  logic                   stop_bad,
    input  logic                   irq_en,
    input  logic                   clr_ready,
    input  logic                   clr_overrun,
    input  logic                   clr_frame,
    input  logic                   clr_parity,
    output logic [RX_MAX_BITS-1:0] rx_data,
    output logic                   ready,
    output logic                   overrun,
    output logic                   frame_err,
    output logic                   parity_err,
    output logic                   irq_rxfull,
    output logic                   irq_rxerr,
    output logic                   hold_off
);
    logic load;

    // Purpose: a character is accepted only when the previous one was read
    always_comb begin
        load = done && !ready;
    end

    // Purpose: receive data register
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_data <= '0;
        else if (load) rx_data <= data_in;
    end

    // Purpose: data-ready flag, set on a clean character
    always_ff @(posedge clk) begin
        if (!rst_n)                             ready <= 1'b0;
        else if (load && !par_bad && !stop_bad) ready <= 1'b1;
        else if (clr_ready)                     ready <= 1'b0;
    end

    // Purpose: overrun flag, set when a character arrives unread
    always_ff @(posedge clk) begin
        if (!rst_n)              overrun <= 1'b0;
        else if (done && ready)  overrun <= 1'b1;
        else if (clr_overrun)    overrun <= 1'b0;
    end

    // Purpose: framing error flag
    always_ff @(posedge clk) begin
        if (!rst_n)                frame_err <= 1'b0;
        else if (load && stop_bad) frame_err <= 1'b1;
        else if (clr_frame)        frame_err <= 1'b0;
    end

    // Purpose: parity error flag
    always_ff @(posedge clk) begin
        if (!rst_n)               parity_err <= 1'b0;
        else if (load && par_bad) parity_err <= 1'b1;
        else if (clr_parity)      parity_err <= 1'b0;
    end

    // Purpose: interrupt requests and the receive hold-off
    always_comb begin
        hold_off   = overrun || frame_err || parity_err;
        irq_rxfull = irq_en && ready;
        irq_rxerr  = irq_en && hold_off;
    end

    // R2
    ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(done));

    // R4
    parity_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parity_err) |-> ($past(done) && !ready));

    // R5
    frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ready && stop_bad) |=> (frame_err && rx_data == $past(data_in) && !ready));

    // R7
    overrun_noload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ready) |=> (overrun && ready && $stable(rx_data)));

    // R11
    clr_frame_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_frame && !done) |=> !frame_err);
endmodule

// File: rtl/serial_rx_core.sv
// Module: serial_rx_core (top)
// Asynchronous serial receiver: line synchroniser, bit framer, frame
// checker and status/flag stage. Assumes os_tick pulses OVS times per bit
// and at most once every few clock cycles (more than SYNC_STAGES apart).
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int unsigned OVS         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    input  logic       os_tick,
    input  logic       cfg_len7,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_two_stop,
    input  logic       irq_en,
    input  logic       clr_ready,
    input  logic       clr_overrun,
    input  logic       clr_frame,
    input  logic       clr_parity,
    output logic [7:0] rx_data,
    output logic       ready,
    output logic       overrun,
    output logic       frame_err,
    output logic       parity_err,
    output logic       irq_rxfull,
    output logic       irq_rxerr
);
    logic                   line_s;
    logic                   hold_off;
    logic                   done;
    rx_frame_t              frame;
    logic [RX_MAX_BITS-1:0] chk_data;
    logic                   par_bad;
    logic                   stop_bad;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (line_in),
        .sync_out (line_s)
    );

    serial_rx_framer #(.OVS(OVS)) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (os_tick),
        .line_s       (line_s),
        .hold_off     (hold_off),
        .cfg_len7     (cfg_len7),
        .cfg_par_en   (cfg_par_en),
        .cfg_two_stop (cfg_two_stop),
        .done         (done),
        .frame        (frame)
    );

    serial_rx_check u_check (
        .frame       (frame),
        .cfg_len7    (cfg_len7),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .data_out    (chk_data),
        .par_bad     (par_bad),
        .stop_bad    (stop_bad)
    );

    serial_rx_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (done),
        .data_in     (chk_data),
        .par_bad     (par_bad),
        .stop_bad    (stop_bad),
        .irq_en      (irq_en),
        .clr_ready   (clr_ready),
        .clr_overrun (clr_overrun),
        .clr_frame   (clr_frame),
        .clr_parity  (clr_parity),
        .rx_data     (rx_data),
        .ready       (ready),
        .overrun     (overrun),
        .frame_err   (frame_err),
        .parity_err  (parity_err),
        .irq_rxfull  (irq_rxfull),
        .irq_rxerr   (irq_rxerr),
        .hold_off    (hold_off)
    );
endmodule

// File: tb/serial_rx_core_bench.sv
// Scoreboard bench: the driver pushes the expected register and flag state
// of each frame into a queue; the monitor pops and compares whenever a flag
// rises.
module serial_rx_core_bench;
    localparam int OVS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b1;
    logic       os_tick = 1'b0;
    logic       cfg_len7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       irq_en = 1'b0;
    logic       clr_ready = 1'b0, clr_overrun = 1'b0, clr_frame = 1'b0, clr_parity = 1'b0;
    logic [7:0] rx_data;
    logic       ready, overrun, frame_err, parity_err, irq_rxfull, irq_rxerr;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [7:0] data;
        logic [3:0] flags;   // {ready, overrun, frame_err, parity_err}
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    serial_rx_core u_serial_rx_core (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .os_tick(os_tick),
        .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .irq_en(irq_en),
        .clr_ready(clr_ready), .clr_overrun(clr_overrun),
        .clr_frame(clr_frame), .clr_parity(clr_parity),
        .rx_data(rx_data), .ready(ready), .overrun(overrun),
        .frame_err(frame_err), .parity_err(parity_err),
        .irq_rxfull(irq_rxfull), .irq_rxerr(irq_rxerr)
    );

    always #4 clk = ~clk;

    // oversampling tick: one clock in four
    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc = (tc + 1) % 4;
            os_tick = (tc == 0);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // monitor: compare on every rising flag
    logic [3:0] prev_flags = 4'b0;
    always @(negedge clk) begin
        logic [3:0] cur;
        cur = {ready, overrun, frame_err, parity_err};
        if (rst_n && ((cur & ~prev_flags) != 4'b0)) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL unexpected flag rise: actual=%0h expected=none", cur);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " data"}, 32'(rx_data), 32'(e.data));
                chk({e.tag, " flags"}, 32'(cur), 32'(e.flags));
            end
        end
        prev_flags = rst_n ? cur : 4'b0;
    end

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!os_tick) @(posedge clk);
        end
    endtask

    task automatic put_bit(input logic v);
        @(negedge clk);
        line_in = v;
        wait_ticks(OVS);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nbits, input logic has_par,
                              input logic pbit, input logic stop1,
                              input logic has_stop2, input logic stop2);
        put_bit(1'b0);
        for (int i = 0; i < nbits; i++) put_bit(d[i]);
        if (has_par) put_bit(pbit);
        put_bit(stop1);
        if (has_stop2) put_bit(stop2);
        @(negedge clk);
        line_in = 1'b1;
        wait_ticks(3 * OVS);
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input logic [3:0] f, input string tag);
        exp_t e;
        e.data = d; e.flags = f; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: clr_ready = 1'b1;
            1: clr_overrun = 1'b1;
            2: clr_frame = 1'b1;
            default: clr_parity = 1'b1;
        endcase
        @(negedge clk);
        clr_ready = 1'b0; clr_overrun = 1'b0; clr_frame = 1'b0; clr_parity = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic par_of(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 rx_data", 32'(rx_data), 0);
        chk("R1 flags", 32'({ready, overrun, frame_err, parity_err}), 0);
        chk("R1 irqs", 32'({irq_rxfull, irq_rxerr}), 0);
        rst_n = 1'b1;
        irq_en = 1'b1;
        wait_ticks(2 * OVS);

        // R2 8-bit LSB first
        push(8'hA5, 4'b1000, "R2 byte A5");
        send_frame(8'hA5, 8, 0, 0, 1, 0, 0);
        chk("R10 irq_rxfull with enable", 32'(irq_rxfull), 1);
        pulse(0);
        chk("R11 clr_ready", 32'(ready), 0);
        chk("R10 irq_rxfull after clear", 32'(irq_rxfull), 0);

        // R3 7-bit
        cfg_len7 = 1'b1;
        push(8'h53, 4'b1000, "R3 seven-bit 53");
        send_frame(8'hD3, 7, 0, 0, 1, 0, 0);
        pulse(0);
        cfg_len7 = 1'b0;

        // R4 parity good, even then odd
        cfg_par_en = 1'b1;
        push(8'h96, 4'b1000, "R4 even good");
        send_frame(8'h96, 8, 1, par_of(8'h96, 0), 1, 0, 0);
        pulse(0);
        cfg_par_odd = 1'b1;
        push(8'h01, 4'b1000, "R4 odd good");
        send_frame(8'h01, 8, 1, par_of(8'h01, 1), 1, 0, 0);
        pulse(0);
        // R4 odd bad
        push(8'h7E, 4'b0001, "R4 odd bad");
        send_frame(8'h7E, 8, 1, ~par_of(8'h7E, 1), 1, 0, 0);
        chk("R10 irq_rxerr with enable", 32'(irq_rxerr), 1);
        // R8 blocked while parity_err set
        send_frame(8'h11, 8, 1, par_of(8'h11, 1), 1, 0, 0);
        chk("R8 data kept while blocked", 32'(rx_data), 32'h7E);
        chk("R8 ready stays 0 while blocked", 32'(ready), 0);
        pulse(3);
        chk("R11 clr_parity", 32'(parity_err), 0);
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

        // R5 framing error, interrupt disabled
        irq_en = 1'b0;
        push(8'h42, 4'b0010, "R5 stop zero");
        send_frame(8'h42, 8, 0, 0, 0, 0, 0);
        chk("R10 irq_rxerr gated off", 32'(irq_rxerr), 0);
        pulse(3);
        chk("R11 clr_parity leaves frame_err", 32'(frame_err), 1);
        pulse(2);
        chk("R11 clr_frame", 32'(frame_err), 0);
        irq_en = 1'b1;

        // R6 second stop bit unchecked
        cfg_two_stop = 1'b1;
        push(8'h81, 4'b1000, "R6 second stop zero");
        send_frame(8'h81, 8, 0, 0, 1, 1, 0);
        pulse(0);
        cfg_two_stop = 1'b0;

        // R9 glitch then real frame
        @(negedge clk);
        line_in = 1'b0;
        wait_ticks(4);
        @(negedge clk);
        line_in = 1'b1;
        wait_ticks(2 * OVS);
        @(negedge clk);
        chk("R9 glitch ignored", 32'({ready, overrun, frame_err, parity_err}), 0);
        push(8'h5A, 4'b1000, "R9 frame after glitch");
        send_frame(8'h5A, 8, 0, 0, 1, 0, 0);

        // R7 overrun: ready still set
        push(8'h5A, 4'b1100, "R7 overrun keeps data");
        send_frame(8'hFF, 8, 0, 0, 1, 0, 0);
        pulse(1);
        chk("R11 clr_overrun leaves ready", 32'({ready, overrun}), 32'b10);
        pulse(0);
        push(8'h0F, 4'b1000, "R7 recovery after overrun");
        send_frame(8'h0F, 8, 0, 0, 1, 0, 0);

        chk("scoreboard drained", 32'(exp_q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule